// File: doc/BRIEF.md
# Table-Driven Register Write Sequencer

This block replays short scripts of register-field updates. Scripts are stored in an internal step table. Each step names a target register, a bit field inside it, the new value for that field, a coded pause and a stop flag. Several scripts share one table. A host starts a script with a single write to a control address, and the written value chooses the step at which execution begins. From there the engine reads the target register, replaces only the chosen field, writes the word back and waits for the step's pause. It then moves to the next step, and it halts after the step whose stop flag is set.

The register file holds 128 words of 16 bits. The host writes it and reads it through its own ports. The sequencer has priority on the write path. While a script runs, host register writes and step-table loads are dropped. Pauses are counted in ticks of a slow timebase. That timebase is divided down from the system clock by a parameter, so a long power-down script can span milliseconds.

Top module: `regseq_engine`

## Requirements
- R1: After reset `busy` and `done` are 0 and every register reads 0.
- R2: A host write to address `CTRL_ADDR` (default 90) with bit 7 of the data set starts a script at the step index held in data bits 6:0. The value 0x009B starts at step 27. The written value is also stored in that register. The same write with bit 7 clear is stored and starts nothing.
- R3: A step rewrites only its field. Register bits outside the field keep their previous value.
- R4: Step word layout is {stop[26], pause[25:22], value[21:14], lsb[13:10], width_minus_1[9:7], addr[6:0]}. The field covers `width_minus_1+1` bits (1 to 8) from bit `lsb` (0 to 8) and takes the low bits of `value`.
- R5: Steps execute at consecutive indices. Execution stops after the first step with the stop bit set, even when that is the starting step.
- R6: A step with pause code 0 takes exactly one cycle. A step with code n>0 takes one cycle plus 2^n timebase ticks of `TICK_DIV` clocks each. `busy` stays high for the sum over the executed steps.
- R7: While `busy` is high, host register writes, trigger writes and step-table loads have no effect.
- R8: `done` rises when a script completes, with `busy` low. It clears on the next accepted trigger.
- R9: A placeholder step that leaves its register value unchanged is still executed in full, including its cycle and its pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_waddr | input | 7 | Host write address |
| host_wdata | input | 16 | Host write data |
| host_raddr | input | 7 | Host read address |
| host_rdata | output | 16 | Register contents at `host_raddr` (combinational) |
| tbl_we | input | 1 | Step-table load strobe |
| tbl_waddr | input | 7 | Step-table load index |
| tbl_wdata | input | 27 | Step word, layout as in R4 |
| busy | output | 1 | Script in progress |
| done | output | 1 | Last script completed |

## Verification
The first script mixes field widths of 1, 3, 4 and 8 bits at low, middle and top positions. Two of its steps touch the same register, which separates a true field merge from a whole-word overwrite or a stale read. A placeholder step and pause codes 0, 1 and 3 make the measured busy length show whether each pause is counted as 2^n ticks or dropped. A trigger with the start bit clear tells storage apart from starting. A script that receives a host write, a retrigger and a table load while it runs shows that the sequencer keeps priority. A single-step script then confirms that the stop flag is honoured on the first step and that `done` clears on the next trigger.

// File: rtl/regseq_pkg.sv
package regseq_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 7;
  localparam int IDX_W  = 7;
  localparam int VAL_W  = 8;
  localparam int DLY_W  = 4;
  localparam int TICK_W = (1 << DLY_W);

  typedef struct packed {
    logic             stop;
    logic [DLY_W-1:0] pause;
    logic [VAL_W-1:0] value;
    logic [3:0]       lsb;
    logic [2:0]       wm1;
    logic [ADDR_W-1:0] addr;
  } step_t;

  localparam int STEP_W = $bits(step_t);

  function automatic logic [REG_W-1:0] field_mask(logic [2:0] wm1, logic [3:0] lsb);
    logic [31:0] ones;
    ones = (32'd1 << ({2'b00, wm1} + 5'd1)) - 32'd1;
    return REG_W'(ones << lsb);
  endfunction

  function automatic logic [REG_W-1:0] field_merge(logic [REG_W-1:0] old, step_t s);
    logic [REG_W-1:0] m;
    m = field_mask(s.wm1, s.lsb);
    return (old & ~m) | ((REG_W'(s.value) << s.lsb) & m);
  endfunction

  function automatic logic [TICK_W-1:0] pause_ticks(logic [DLY_W-1:0] code);
    return TICK_W'(1) << code;
  endfunction
endpackage

// File: rtl/regseq_tick.sv
module regseq_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  assign tick = !clr && (cnt == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/regseq_table.sv
module regseq_table
  import regseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_we,
  input  logic [IDX_W-1:0] ld_idx,
  input  step_t            ld_step,
  input  logic             busy,
  input  logic [IDX_W-1:0] rd_idx,
  output step_t            rd_step
);
  localparam int DEPTH = 1 << IDX_W;
  step_t mem [DEPTH];

  assign rd_step = mem[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (ld_we && !busy) begin
      mem[ld_idx] <= ld_step;
    end
  end
endmodule

// File: rtl/regseq_regfile.sv
module regseq_regfile
  import regseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_waddr,
  input  logic [REG_W-1:0]  host_wdata,
  input  logic [ADDR_W-1:0] host_raddr,
  output logic [REG_W-1:0]  host_rdata,
  input  logic              seq_we,
  input  logic [ADDR_W-1:0] seq_addr,
  input  logic [REG_W-1:0]  seq_wdata,
  output logic [REG_W-1:0]  seq_rdata
);
  localparam int NREG = 1 << ADDR_W;
  logic [REG_W-1:0] regs [NREG];
  logic host_take;

  assign host_take  = host_we && !busy && !seq_we;
  assign host_rdata = regs[host_raddr];
  assign seq_rdata  = regs[seq_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (seq_we) begin
      regs[seq_addr] <= seq_wdata;
    end else if (host_take) begin
      regs[host_waddr] <= host_wdata;
    end
  end

  AST_SEQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    seq_we |-> busy); // R7
endmodule

// File: rtl/regseq_ctrl.sv
module regseq_ctrl
  import regseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic [IDX_W-1:0] trig_idx,
  input  step_t            step,
  input  logic [REG_W-1:0] old_word,
  input  logic             tick,
  output logic [IDX_W-1:0] idx,
  output logic             wr_en,
  output logic [REG_W-1:0] wr_word,
  output logic             waiting,
  output logic             busy,
  output logic             done
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_WAIT} state_t;
  state_t           state;
  logic [TICK_W-1:0] ticks_left;
  logic             step_end;

  assign wr_en    = (state == S_RUN);
  assign wr_word  = field_merge(old_word, step);
  assign waiting  = (state == S_WAIT);
  assign busy     = (state != S_IDLE);
  assign step_end = (wr_en && step.pause == '0) ||
                    (waiting && tick && ticks_left == TICK_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      idx        <= '0;
      ticks_left <= '0;
      done       <= 1'b0;
    end else begin
      if (state == S_IDLE) begin
        if (trig) begin
          idx   <= trig_idx;
          state <= S_RUN;
          done  <= 1'b0;
        end
      end else begin
        if (wr_en && step.pause != '0) begin
          ticks_left <= pause_ticks(step.pause);
          state      <= S_WAIT;
        end else if (waiting && tick) begin
          ticks_left <= ticks_left - 1'b1;
        end
        if (step_end) begin
          if (step.stop) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end else begin
            idx   <= idx + 1'b1;
            state <= S_RUN;
          end
        end
      end
    end
  end

  AST_TRIG_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !busy) |=> (busy && !done)); // R2
  AST_FIELD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (((wr_word ^ old_word) & ~field_mask(step.wm1, step.lsb)) == '0)); // R3
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_end && !step.stop) |=> (idx == $past(idx) + 1'b1)); // R5
  AST_WAIT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> (ticks_left != '0)); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8
endmodule

// File: rtl/regseq_engine.sv
module regseq_engine
  import regseq_pkg::*;
#(
  parameter int TICK_DIV  = 4,
  parameter int CTRL_ADDR = 90,
  parameter int GO_BIT    = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_we,
  input  logic [ADDR_W-1:0]   host_waddr,
  input  logic [REG_W-1:0]    host_wdata,
  input  logic [ADDR_W-1:0]   host_raddr,
  output logic [REG_W-1:0]    host_rdata,
  input  logic                tbl_we,
  input  logic [IDX_W-1:0]    tbl_waddr,
  input  logic [STEP_W-1:0]   tbl_wdata,
  output logic                busy,
  output logic                done
);
  logic             trig;
  logic [IDX_W-1:0] cur_idx;
  step_t            cur_step;
  logic [REG_W-1:0] old_word, new_word;
  logic             seq_we, waiting, tick;

  assign trig = host_we && !busy && (host_waddr == ADDR_W'(CTRL_ADDR)) && host_wdata[GO_BIT];

  regseq_table u_table (
    .clk(clk), .rst_n(rst_n), .ld_we(tbl_we), .ld_idx(tbl_waddr),
    .ld_step(step_t'(tbl_wdata)), .busy(busy), .rd_idx(cur_idx), .rd_step(cur_step)
  );

  regseq_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .host_we(host_we), .host_waddr(host_waddr), .host_wdata(host_wdata),
    .host_raddr(host_raddr), .host_rdata(host_rdata),
    .seq_we(seq_we), .seq_addr(cur_step.addr), .seq_wdata(new_word), .seq_rdata(old_word)
  );

  regseq_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(!waiting), .tick(tick)
  );

  regseq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .trig(trig), .trig_idx(host_wdata[IDX_W-1:0]),
    .step(cur_step), .old_word(old_word), .tick(tick), .idx(cur_idx),
    .wr_en(seq_we), .wr_word(new_word), .waiting(waiting), .busy(busy), .done(done)
  );

  AST_TICK_ONLY_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> waiting); // R6
endmodule

// File: tb/regseq_engine_tb.sv
module regseq_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;

  logic        clk = 0, rst_n = 0;
  logic        host_we = 0;
  logic [6:0]  host_waddr = 0, host_raddr = 0, tbl_waddr = 0;
  logic [15:0] host_wdata = 0;
  logic [15:0] host_rdata;
  logic        tbl_we = 0;
  logic [26:0] tbl_wdata = 0;
  logic        busy, done;

  regseq_engine #(.TICK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_waddr(host_waddr),
    .host_wdata(host_wdata), .host_raddr(host_raddr), .host_rdata(host_rdata),
    .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
    .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { int addr; logic [15:0] exp; string req; } sb_item_t;
  sb_item_t    sbq[$];
  int          errors = 0, checks = 0;
  logic [15:0] model [128];
  logic [26:0] btab  [128];
  int          touched[$];
  int          busy_cnt = 0, exp_busy = 0;
  bit          finished = 0;

  always @(negedge clk) if (busy) busy_cnt++;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected register contents and compares them at the read port
  initial begin
    forever begin
      @(negedge clk);
      if (sbq.size() > 0) begin
        sb_item_t it;
        it = sbq.pop_front();
        host_raddr = 7'(it.addr);
        #1;
        check(it.req, {16'h0, host_rdata}, {16'h0, it.exp});
      end
    end
  end

  task automatic drain();
    while (sbq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic push(int a, string req);
    sb_item_t it;
    it.addr = a; it.exp = model[a]; it.req = req;
    sbq.push_back(it);
  endtask

  function automatic logic [26:0] mk(int a, int w, int s, int v, int d, bit e);
    return {e, 4'(d), 8'(v), 4'(s), 3'(w - 1), 7'(a)};
  endfunction

  task automatic host_wr(int a, logic [15:0] d);
    @(negedge clk);
    host_we = 1; host_waddr = 7'(a); host_wdata = d;
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic tbl_ld(int i, logic [26:0] e, bit take);
    @(negedge clk);
    tbl_we = 1; tbl_waddr = 7'(i); tbl_wdata = e;
    if (take) btab[i] = e;
    @(negedge clk);
    tbl_we = 0;
  endtask

  // bench model: bit-by-bit field replacement and per-step duration
  task automatic run_start(logic [15:0] tv);
    int i;
    bit stop;
    model[90] = tv;
    touched.delete();
    exp_busy = 0;
    i = int'(tv[6:0]);
    stop = 0;
    while (!stop) begin
      logic [26:0] e;
      int a, w, s, d;
      e = btab[i];
      a = int'(e[6:0]); w = int'(e[9:7]) + 1; s = int'(e[13:10]); d = int'(e[25:22]);
      for (int b = 0; b < w; b++) if (s + b < 16) model[a][s+b] = e[14+b];
      exp_busy += 1 + ((d != 0) ? (1 << d) * DIV : 0);
      touched.push_back(a);
      stop = e[26];
      i = (i + 1) % 128;
    end
    busy_cnt = 0;
    host_wr(90, tv);
    check("R2 busy after trigger", busy, 1);
    check("R8 done cleared by trigger", done, 0);
  endtask

  task automatic run_finish(string tag);
    while (busy) @(negedge clk);
    check({tag, " R6 busy cycles"}, busy_cnt, exp_busy);
    check("R8 done at end", done, 1);
    foreach (touched[k]) push(touched[k], {tag, " R3 field result"});
    drain();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 128; k++) begin model[k] = 0; btab[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 busy reset", busy, 0);
    check("R1 done reset", done, 0);
    push(5, "R1 reg reset"); push(90, "R1 reg reset");
    drain();

    // script at 27: mixed widths, shared register, placeholder (R4 R9)
    host_wr(5, 16'hFFFF);  model[5]  = 16'hFFFF;
    host_wr(3, 16'h1234);  model[3]  = 16'h1234;
    host_wr(20, 16'h00FF); model[20] = 16'h00FF;
    tbl_ld(27, mk(5, 3, 3, 0, 3, 0), 1);
    tbl_ld(28, mk(3, 8, 8, 8'hA5, 0, 0), 1);
    tbl_ld(29, mk(20, 1, 0, 0, 0, 0), 1);
    tbl_ld(30, mk(100, 2, 2, 0, 0, 0), 1);   // R9 placeholder, no value change
    tbl_ld(31, mk(3, 4, 0, 8'h0C, 1, 1), 1);
    tbl_ld(32, mk(20, 8, 0, 8'h00, 0, 1), 1); // beyond stop: must not run (R5)
    run_start(16'h009B);
    run_finish("T1 R4 R5 R9");
    check("R3 reg5 expected FFC7", {16'h0, model[5]}, 32'hFFC7);
    push(20, "R5 step past stop untouched");
    drain();

    // trigger value with bit 7 clear: stored only
    host_wr(90, 16'h001B); model[90] = 16'h001B;
    @(negedge clk);
    check("R2 no start without go bit", busy, 0);
    push(90, "R2 value stored"); push(5, "R2 no script effect");
    drain();

    // script at 40 with host activity while busy (R7)
    tbl_ld(60, mk(9, 8, 4, 8'h81, 0, 1), 1);
    tbl_ld(40, mk(7, 5, 8, 8'h1F, 2, 0), 1);
    tbl_ld(41, mk(7, 8, 0, 8'h3C, 0, 1), 1);
    run_start(16'h00A8);
    host_wr(7, 16'hFFFF);
    host_wr(90, 16'h00BC);
    tbl_ld(60, mk(9, 1, 0, 1, 0, 1), 0);
    run_finish("T3 R7");
    push(90, "R7 host write dropped while busy");
    drain();
    check("R7 no retrigger", busy, 0);

    // single-step script at 60 uses the table word loaded while idle
    run_start(16'h00BC);
    run_finish("T4 R5 R7");
    check("R7 reg9 expected 0810", {16'h0, model[9]}, 32'h0810);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule